// File: doc/BRIEF.md
# Serial Transmitter with Line Break and Clear-to-Send Gating

This block turns bytes into an asynchronous serial character stream on a single output line. A producer, typically the read side of a FIFO, offers a byte with a strobe. The byte is taken on any clock where the strobe is high and the busy output is low, so that same condition can double as the FIFO pop. A 31-bit setup word, shared with the matching receiver, is applied at run time. It selects the clocks per bit, the character length, the parity mode, the number of stop bits, and whether hardware flow control is honoured.

Two line-control features sit on top of plain serialisation. A break input drives the line low for as long as it is held and abandons any character in flight. Once break is released, the next byte goes out as a normal character. An active-low clear-to-send input, passed through a two-flop synchronizer, holds back the start of the next character while the far end reports that it is not ready. It is consulted only between characters, so a character that has started always finishes. Setting setup bit 30 disables this gating. When the block is built with `FLOW_BUILT = 0`, the gating is always off.

Top module: `uartTxBreakCts`

## Requirements
- R1: While reset is active and after it is released, `txOut` is high (idle). With no break and flow control off (setup bit 30 = 1), `busy` is low within three clocks of reset release.
- R2: A byte is accepted when `strobe` is high on a clock where `busy` is low. From the next cycle, `busy` is high and the start bit (low) is on `txOut`. Each bit lasts N clocks, where N is setup[23:0] and a value of 0 counts as 1.
- R3: After the start bit, the data bits go out least significant bit first. The length code setup[29:28] selects 00 = 8, 01 = 7, 10 = 6 or 11 = 5 data bits. Any unused upper bits of `dataIn` are ignored.
- R4: When setup[26] = 1, a parity bit follows the data. With setup[25] = 0, the parity is even when setup[24] = 0 and odd when setup[24] = 1. With setup[25] = 1, the parity bit is fixed to the value of setup[24].
- R5: A character ends with one high stop bit, or two when setup[27] = 1. `busy` stays high until the last stop bit has lasted its full N clocks and falls on the very next cycle.
- R6: A strobe raised while `busy` is high has no effect: the character in flight is unchanged and no extra character follows.
- R7: When setup[30] = 0 and `ctsN` has been high for two clocks, `busy` is high, no character starts and `txOut` stays high. When `ctsN` is low, or when setup[30] = 1, characters start normally.
- R8: A change of `ctsN` in the middle of a character does not disturb that character. The change only governs whether the next character may start.
- R9: While `breakIn` is high, `txOut` is low from the next cycle onward and `busy` is high, and any character in progress is abandoned. After `breakIn` falls, `txOut` returns high on the next cycle and the next byte is sent as a normal character.
- R10: A change to the setup word during a character does not alter that character. The new settings apply from the next accepted byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| setup | input | 31 | Runtime setup word: divisor, length, parity, stop bits, flow-control disable |
| breakIn | input | 1 | Hold the line low while high |
| strobe | input | 1 | Byte offered on `dataIn` |
| dataIn | input | 8 | Byte to send |
| ctsN | input | 1 | Active-low clear-to-send from the far end |
| txOut | output | 1 | Serial line, idle high |
| busy | output | 1 | High when a byte cannot be accepted |

## Verification
The assertions assume that every input is driven to a known value from time zero. They also assume that reset is held for at least two clocks, so that the clear-to-send history they look back on lies inside the synchronizer's reset window. The flow-control property assumes that setup bit 30 is static across the two clocks it examines. The bench keeps to these conditions: it drives all inputs at time zero, holds reset for several clocks, and changes the setup word only on falling clock edges while no clear-to-send transition is pending. It also raises the strobe together with break only in ways that do not lose a byte the checks depend on.

// File: rtl/uartTxPkg.sv
package uartTxPkg;
  // setup word layout
  localparam int SETUP_W     = 31;
  localparam int DIV_W       = 24;
  localparam int PAR_SEL_BIT = 24;
  localparam int PAR_FIX_BIT = 25;
  localparam int PAR_EN_BIT  = 26;
  localparam int STOP2_BIT   = 27;
  localparam int LEN_LO_BIT  = 28;
  localparam int FLOW_OFF_BIT = 30;

  localparam int MAX_DATA  = 8;
  localparam int FRAME_MAX = 1 + MAX_DATA + 1 + 2;  // start, data, parity, two stops
  localparam int IDX_W     = $clog2(FRAME_MAX);

  typedef enum logic {ST_IDLE, ST_SEND} txStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic forceLow;  // break: line low
    logic load;      // new character: load frame, drive start bit
    logic shift;     // bit time over: drive next bit
    logic idle;      // between characters: line high
  } txStrobeT;
endpackage

// File: rtl/uartTxCtl.sv
module uartTxCtl
  import uartTxPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       lenCode,
  input  logic             parEn,
  input  logic             stop2,
  input  logic             flowOff,
  input  logic             strobe,
  input  logic             breakIn,
  input  logic             ctsN,
  output logic             busyOut,
  output txStrobeT         stb
);
  txStateT          state;
  logic             breakQ;
  logic [1:0]       ctsSync;
  logic [DIV_W-1:0] baudCnt;
  logic [DIV_W-1:0] reloadQ;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] lastIdxQ;

  logic             ctsBlock;
  logic             accept;
  logic             atBitEnd;
  logic             lastBit;
  logic [DIV_W-1:0] reloadNow;
  logic [IDX_W-1:0] lastIdxNow;

  always_comb begin
    reloadNow  = (divisor == '0) ? '0 : divisor - 1'b1;
    // frame length minus one = data bits + parity + stop bits
    lastIdxNow = IDX_W'(MAX_DATA) - IDX_W'(lenCode) + IDX_W'(parEn)
                 + IDX_W'(stop2) + IDX_W'(1);
    ctsBlock   = !flowOff && ctsSync[1];
    busyOut    = (state == ST_SEND) || breakQ || ctsBlock;
    accept     = strobe && !busyOut;
    atBitEnd   = (state == ST_SEND) && (baudCnt == '0);
    lastBit    = atBitEnd && (bitIdx == lastIdxQ);

    stb.forceLow = breakIn;
    stb.load     = accept && !breakIn;
    stb.shift    = atBitEnd && !lastBit && !breakIn;
    stb.idle     = lastBit || ((state == ST_IDLE) && !accept);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      breakQ   <= 1'b0;
      ctsSync  <= 2'b11;
      baudCnt  <= '0;
      reloadQ  <= '0;
      bitIdx   <= '0;
      lastIdxQ <= '0;
    end else begin
      breakQ  <= breakIn;
      ctsSync <= {ctsSync[0], ctsN};
      if (breakIn) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: if (accept) begin
            state    <= ST_SEND;
            baudCnt  <= reloadNow;
            reloadQ  <= reloadNow;
            bitIdx   <= '0;
            lastIdxQ <= lastIdxNow;
          end
          ST_SEND: if (lastBit) begin
            state <= ST_IDLE;
          end else if (atBitEnd) begin
            bitIdx  <= bitIdx + 1'b1;
            baudCnt <= reloadQ;
          end else begin
            baudCnt <= baudCnt - 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uartTxDp.sv
module uartTxDp
  import uartTxPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          lenCode,
  input  logic                parEn,
  input  logic                parFix,
  input  logic                parSel,
  input  logic [MAX_DATA-1:0] dataIn,
  input  txStrobeT            stb,
  output logic                txOut
);
  logic [FRAME_MAX-1:0] frame;
  logic [FRAME_MAX-2:0] shReg;
  logic [IDX_W-1:0]     nData;
  logic                 parAcc;

  always_comb begin
    nData  = IDX_W'(MAX_DATA) - IDX_W'(lenCode);
    frame  = '1;       // stop bits and padding are high
    frame[0] = 1'b0;   // start bit
    parAcc = 1'b0;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (IDX_W'(i) < nData) begin
        frame[i + 1] = dataIn[i];
        parAcc       = parAcc ^ dataIn[i];
      end
    end
    if (parEn) frame[nData + 1'b1] = parFix ? parSel : (parAcc ^ parSel);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txOut <= 1'b1;
      shReg <= '1;
    end else if (stb.forceLow) begin
      txOut <= 1'b0;
    end else if (stb.load) begin
      txOut <= frame[0];
      shReg <= frame[FRAME_MAX-1:1];
    end else if (stb.shift) begin
      txOut <= shReg[0];
      shReg <= {1'b1, shReg[FRAME_MAX-2:1]};
    end else if (stb.idle) begin
      txOut <= 1'b1;
    end
  end
endmodule

// File: rtl/uartTxBreakCts.sv
module uartTxBreakCts
  import uartTxPkg::*;
#(
  parameter bit FLOW_BUILT = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SETUP_W-1:0] setup,
  input  logic               breakIn,
  input  logic               strobe,
  input  logic [MAX_DATA-1:0] dataIn,
  input  logic               ctsN,
  output logic               txOut,
  output logic               busy
);
  txStrobeT stb;
  logic     flowOff;

  generate
    if (FLOW_BUILT) begin : g_flow
      assign flowOff = setup[FLOW_OFF_BIT];
    end else begin : g_noFlow
      assign flowOff = 1'b1;
    end
  endgenerate

  uartTxCtl ctl (
    .clk     (clk),
    .rstN    (rstN),
    .divisor (setup[DIV_W-1:0]),
    .lenCode (setup[LEN_LO_BIT+1:LEN_LO_BIT]),
    .parEn   (setup[PAR_EN_BIT]),
    .stop2   (setup[STOP2_BIT]),
    .flowOff (flowOff),
    .strobe  (strobe),
    .breakIn (breakIn),
    .ctsN    (ctsN),
    .busyOut (busy),
    .stb     (stb)
  );

  uartTxDp dp (
    .clk     (clk),
    .rstN    (rstN),
    .lenCode (setup[LEN_LO_BIT+1:LEN_LO_BIT]),
    .parEn   (setup[PAR_EN_BIT]),
    .parFix  (setup[PAR_FIX_BIT]),
    .parSel  (setup[PAR_SEL_BIT]),
    .dataIn  (dataIn),
    .stb     (stb),
    .txOut   (txOut)
  );
endmodule

// File: rtl/uartTxChk.sv
module uartTxChk #(
  parameter bit FLOW_BUILT = 1'b1
) (
  input logic clk,
  input logic rstN,
  input logic flowOff,
  input logic breakIn,
  input logic strobe,
  input logic ctsN,
  input logic txOut,
  input logic busy
);
  // R2: an accepted byte starts with busy high and a low start bit
  p_start_bit_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe && !busy && !breakIn |=> busy && !txOut);

  // R9: break holds the line low and the block busy
  p_break_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    breakIn |=> !txOut && busy);

  // R1: whenever a byte could be taken, the line is idle high
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txOut);

  // R7: far end not ready for two clocks with gating on keeps the block busy
  p_cts_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    FLOW_BUILT && !flowOff && $past(ctsN, 2) && $past(ctsN) |-> busy);

  // R9: break release returns the line high on the next cycle
  p_break_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(breakIn) |=> txOut);
endmodule

bind uartTxBreakCts uartTxChk #(.FLOW_BUILT(FLOW_BUILT)) chk (
  .clk     (clk),
  .rstN    (rstN),
  .flowOff (setup[30]),
  .breakIn (breakIn),
  .strobe  (strobe),
  .ctsN    (ctsN),
  .txOut   (txOut),
  .busy    (busy)
);

// File: tb/uartTxBreakCts_test.sv
module uartTxBreakCts_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [30:0] setup = '0;
  logic        breakIn = 1'b0;
  logic        strobe = 1'b0;
  logic [7:0]  dataIn = '0;
  logic        ctsN = 1'b0;
  logic        txOut;
  logic        busy;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  uartTxBreakCts uut (
    .clk(clk), .rstN(rstN), .setup(setup), .breakIn(breakIn),
    .strobe(strobe), .dataIn(dataIn), .ctsN(ctsN),
    .txOut(txOut), .busy(busy)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string req, input string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [30:0] mkSetup(input bit flowOff, input int len,
      input bit stop2, input bit parEn, input bit parFix, input bit parSel,
      input int div);
    return {flowOff, 2'(len), stop2, parEn, parFix, parSel, 24'(div)};
  endfunction

  function automatic int nBits(input logic [30:0] s);
    return 8 - int'(s[29:28]);
  endfunction

  function automatic int frameLen(input logic [30:0] s);
    return 1 + nBits(s) + int'(s[26]) + 1 + int'(s[27]);
  endfunction

  function automatic int divOf(input logic [30:0] s);
    return (s[23:0] == 0) ? 1 : int'(s[23:0]);
  endfunction

  function automatic logic [11:0] expFrame(input logic [7:0] d, input logic [30:0] s);
    logic [11:0] f;
    int ones;
    int n;
    f = '1;
    f[0] = 1'b0;
    n = nBits(s);
    ones = 0;
    for (int i = 0; i < n; i++) begin
      f[1 + i] = d[i];
      ones += int'(d[i]);
    end
    if (s[26]) f[1 + n] = s[25] ? s[24] : (((ones % 2) == 1) ^ s[24]);
    return f;
  endfunction

  task automatic sendChar(input logic [7:0] d, input logic [30:0] s,
      input string req, input int ctsAt, input bit poke,
      input int setAt, input logic [30:0] sLater);
    logic [11:0] f;
    int dv;
    int total;
    f = expFrame(d, s);
    dv = divOf(s);
    total = frameLen(s) * dv;
    while (busy) @(negedge clk);
    setup = s;
    dataIn = d;
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    for (int k = 0; k < total; k++) begin
      chk(txOut, f[k / dv], req, $sformatf("line k=%0d byte %0h", k, d));
      chk(busy, 1, req, $sformatf("busy k=%0d", k));
      if (k == ctsAt) ctsN = 1'b1;
      if (k == setAt) setup = sLater;
      if (poke) begin
        strobe = (k >= 1) && (k < total - 2);
        dataIn = ~d;
      end
      @(negedge clk);
    end
    strobe = 1'b0;
    chk(txOut, 1, req, "line after stop");
    chk(busy, (ctsAt >= 0) ? 1 : 0, req, "busy after stop");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [30:0] sA;
    logic [30:0] sB;
    // R1: reset state
    setup = mkSetup(1, 0, 0, 0, 0, 0, 2);
    repeat (3) @(negedge clk);
    chk(txOut, 1, "R1", "line in reset");
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(txOut, 1, "R1", "line after reset");
    chk(busy, 0, "R1", "busy after reset");

    // R3: every byte value, 8 data bits, no parity, one stop, divisor 1
    for (int b = 0; b < 256; b++)
      sendChar(8'(b), mkSetup(1, 0, 0, 0, 0, 0, 1), "R3", -1, 0, -1, '0);

    // R2 R3 R4 R5: sweep divisor (0 counts as 1), length, parity mode, stops
    for (int dv = 0; dv < 4; dv++)
      for (int ln = 0; ln < 4; ln++)
        for (int pm = 0; pm < 5; pm++)
          for (int st = 0; st < 2; st++)
            for (int p = 0; p < 8; p++)
              sendChar(8'(p * 75 + 17),
                       mkSetup(1, ln, st[0], pm != 0, pm >= 3, (pm == 2) || (pm == 4), dv),
                       "R2_R3_R4_R5", -1, 0, -1, '0);

    // R6: strobes during a character are ignored
    sendChar(8'hC3, mkSetup(1, 0, 1, 1, 0, 1, 3), "R6", -1, 1, -1, '0);
    repeat (2) @(negedge clk);
    chk(txOut, 1, "R6", "no extra character");
    chk(busy, 0, "R6", "no extra character busy");

    // R7: far end not ready blocks character starts
    setup = mkSetup(0, 0, 0, 0, 0, 0, 2);
    ctsN = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy, 1, "R7", "busy while cts high");
    strobe = 1'b1;
    dataIn = 8'h00;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(txOut, 1, "R7", "line held idle");
    end
    strobe = 1'b0;
    setup = mkSetup(1, 0, 0, 0, 0, 0, 2);
    #1;
    chk(busy, 0, "R7", "bit 30 bypasses cts");
    @(negedge clk);
    setup = mkSetup(0, 0, 0, 0, 0, 0, 2);
    ctsN = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy, 0, "R7", "busy after cts low");
    sendChar(8'h96, mkSetup(0, 0, 0, 1, 0, 0, 2), "R7", -1, 0, -1, '0);

    // R8: cts going high mid-character does not disturb it
    sendChar(8'h3A, mkSetup(0, 0, 0, 0, 0, 0, 2), "R8", 3, 0, -1, '0);
    repeat (3) @(negedge clk);
    chk(busy, 1, "R8", "next start held");
    chk(txOut, 1, "R8", "line idle while held");
    ctsN = 1'b0;
    repeat (3) @(negedge clk);

    // R9: break forces the line low and aborts a character
    setup = mkSetup(1, 0, 0, 0, 0, 0, 3);
    dataIn = 8'hFF;
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    repeat (4) @(negedge clk);
    chk(txOut, 1, "R9", "data bit before break");
    breakIn = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(txOut, 0, "R9", "line low in break");
      chk(busy, 1, "R9", "busy in break");
    end
    breakIn = 1'b0;
    @(negedge clk);
    chk(txOut, 1, "R9", "line high after break");
    chk(busy, 0, "R9", "busy after break");
    sendChar(8'h55, mkSetup(1, 0, 0, 0, 0, 0, 3), "R9", -1, 0, -1, '0);

    // R10: setup change mid-character applies from the next byte
    sA = mkSetup(1, 0, 0, 0, 0, 0, 2);
    sB = mkSetup(1, 3, 1, 1, 0, 1, 3);
    sendChar(8'hE7, sA, "R10", -1, 0, 2, sB);
    sendChar(8'h2D, sB, "R10", -1, 0, -1, '0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule